// File: doc/BRIEF.md
# Single-Bus Processor Datapath

This block is the data half of a small microcoded processor. Every value moves over one shared 32-bit bus, and in any cycle exactly one source may drive it: the immediate generator, the ALU, the register file or the memory read port. The sinks on the bus are the instruction register, two ALU operand registers, a memory-address register, the register file and the memory write port. Each sink captures the bus on the rising clock edge when its load control is high.

An external microcode sequencer drives every enable, load and select pin. It reads back the current opcode and a flag that shows whether operand A is zero, and it uses them to branch. The memory array is outside the block. The block presents the address, the write data and the write strobe, and it takes the read data back in. The register file has a fixed entry that holds the program counter and the link value, so the sequencer can fetch instructions with the same bus moves it uses for any other transfer.

No data stream crosses the block edge with flow control. The memory port and the sequencer pins are plain control and status signals, and the sequencer accounts for memory latency by holding its controls. For that reason there is no valid/ready handshake and no back-pressure.

Top module: `sbus_datapath`

## Requirements
- R1: The bus value is the output of whichever source has its drive pin high: `drv_imm_i`, `drv_alu_i`, `drv_reg_i` or `drv_mem_i`. With no drive pin high, the bus reads 0. Two drive pins high in the same cycle is an illegal control pattern.
- R2: The instruction register, operand A, operand B and the memory-address register each capture the bus on the clock edge when their load pin (`ld_ir_i`, `ld_a_i`, `ld_b_i`, `ld_ma_i`) is high. Otherwise they hold their value.
- R3: `reg_sel_i` picks the register-file entry as follows: 0 = source field IR[25:21], 1 = target field IR[20:16], 2 = destination field IR[15:11], 3 = the fixed program-counter/link entry (index REG_CNT-1, which is 31). That entry drives the bus under `drv_reg_i`, and it is written from the bus on the edge when `reg_wr_i` is high.
- R4: Entry 0 always reads as zero, and writes to it are ignored.
- R5: `ext_sel_i` forms the immediate from the IR as follows: 0 = IR[15:0] sign-extended, 1 = IR[15:0] sign-extended and shifted left by 2, 2 = IR[25:0] zero-extended, 3 = IR[15:0] zero-extended.
- R6: `alu_op_i` sets the ALU function on A and B as follows: 0 add, 1 subtract (A-B), 2 AND, 3 OR, 4 XOR, 5 signed less-than (result 1 or 0), 6 A+4, 7 jump target {A[31:28], B[25:0], 2'b00}.
- R7: `opcode_o` is IR[31:26]. `a_zero_o` is high exactly when operand A holds zero.
- R8: `mem_addr_o` is the memory-address register. `mem_wdata_o` is the bus. `mem_we_o` follows `mem_wr_i` (1 = write, 0 = read). `mem_rdata_i` reaches the bus under `drv_mem_i`.
- R9: Reset (`rst_ni` low) clears IR, A, B, the memory-address register and every register-file entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| drv_imm_i | input | 1 | Immediate generator drives the bus |
| drv_alu_i | input | 1 | ALU drives the bus |
| drv_reg_i | input | 1 | Selected register entry drives the bus |
| drv_mem_i | input | 1 | Memory read data drives the bus |
| ld_ir_i | input | 1 | Load the instruction register from the bus |
| ld_a_i | input | 1 | Load operand A from the bus |
| ld_b_i | input | 1 | Load operand B from the bus |
| ld_ma_i | input | 1 | Load the memory-address register from the bus |
| reg_sel_i | input | 2 | Register-file index source |
| reg_wr_i | input | 1 | Write the selected entry from the bus |
| ext_sel_i | input | 2 | Immediate format |
| alu_op_i | input | 3 | ALU function |
| mem_wr_i | input | 1 | Memory direction request |
| mem_rdata_i | input | 32 | Memory read data |
| mem_addr_o | output | 32 | Memory address |
| mem_wdata_o | output | 32 | Memory write data (the bus) |
| mem_we_o | output | 1 | Memory write strobe |
| opcode_o | output | 6 | Opcode field, sent to the sequencer |
| a_zero_o | output | 1 | Operand A is zero |
| bus_o | output | 32 | Current bus value |

## Verification
The bench builds the block with DATA_W = 32 and REG_CNT = 32. With these values the three IR index fields cover the whole file, and the link slot falls on entry 31. One instruction word routes the source and target fields to entry 0, so the hardwired-zero read and the discarded write can both be seen at the bus. A negative 16-bit field, together with an operand A that has its top nibble set, reaches the sign-extension, signed-compare and jump-target paths that a small positive word never touches.

// File: rtl/sbd_pkg.sv
package sbd_pkg;
  typedef enum logic [1:0] {
    RSEL_SRC  = 2'd0,
    RSEL_TGT  = 2'd1,
    RSEL_DST  = 2'd2,
    RSEL_LINK = 2'd3
  } rsel_e;

  typedef enum logic [1:0] {
    EXT_SIMM = 2'd0,
    EXT_BOFS = 2'd1,
    EXT_JIDX = 2'd2,
    EXT_ZIMM = 2'd3
  } ext_e;

  typedef enum logic [2:0] {
    ALU_ADD  = 3'd0,
    ALU_SUB  = 3'd1,
    ALU_AND  = 3'd2,
    ALU_OR   = 3'd3,
    ALU_XOR  = 3'd4,
    ALU_SLT  = 3'd5,
    ALU_INC  = 3'd6,
    ALU_JTGT = 3'd7
  } alu_e;

  localparam int OPC_W    = 6;
  localparam int SRC_LSB  = 21;
  localparam int TGT_LSB  = 16;
  localparam int DST_LSB  = 11;
  localparam int IMM_W    = 16;
  localparam int JIDX_W   = 26;
endpackage

// File: rtl/sbd_regfile.sv
module sbd_regfile #(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  localparam int IDX_W  = $clog2(REG_CNT)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wr_data_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [DATA_W-1:0] ent_q [REG_CNT];

  always_ff @(posedge clk_i) begin
    for (int i = 0; i < REG_CNT; i++) begin
      if (!rst_ni) begin
        ent_q[i] <= '0;
      end else if (wr_en_i && (i != 0) && (idx_i == IDX_W'(i))) begin
        ent_q[i] <= wr_data_i;
      end
    end
  end

  // entry zero is hardwired: its flop never leaves reset value
  assign rd_data_o = (idx_i == '0) ? '0 : ent_q[idx_i];
endmodule

// File: rtl/sbd_immgen.sv
module sbd_immgen
  import sbd_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic [DATA_W-1:0] ir_i,
  input  logic [1:0]        ext_sel_i,
  output logic [DATA_W-1:0] imm_o
);
  logic [IMM_W-1:0] fld16;
  logic [DATA_W-1:0] sext16;

  assign fld16  = ir_i[IMM_W-1:0];
  assign sext16 = {{(DATA_W-IMM_W){fld16[IMM_W-1]}}, fld16};

  always_comb begin
    unique case (ext_e'(ext_sel_i))
      EXT_SIMM: imm_o = sext16;
      EXT_BOFS: imm_o = {sext16[DATA_W-3:0], 2'b00};
      EXT_JIDX: imm_o = {{(DATA_W-JIDX_W){1'b0}}, ir_i[JIDX_W-1:0]};
      default:  imm_o = {{(DATA_W-IMM_W){1'b0}}, fld16};
    endcase
  end
endmodule

// File: rtl/sbd_alu.sv
module sbd_alu
  import sbd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int INC_STEP = 4
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [2:0]        op_i,
  output logic [DATA_W-1:0] y_o
);
  localparam int TOP_W = DATA_W - JIDX_W - 2;

  logic lt;
  assign lt = $signed(a_i) < $signed(b_i);

  always_comb begin
    unique case (alu_e'(op_i))
      ALU_ADD:  y_o = a_i + b_i;
      ALU_SUB:  y_o = a_i - b_i;
      ALU_AND:  y_o = a_i & b_i;
      ALU_OR:   y_o = a_i | b_i;
      ALU_XOR:  y_o = a_i ^ b_i;
      ALU_SLT:  y_o = {{(DATA_W-1){1'b0}}, lt};
      ALU_INC:  y_o = a_i + DATA_W'(INC_STEP);
      default:  y_o = {a_i[DATA_W-1 -: TOP_W], b_i[JIDX_W-1:0], 2'b00};
    endcase
  end
endmodule

// File: rtl/sbus_datapath.sv
module sbus_datapath
  import sbd_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int REG_CNT = 32,
  parameter int INC_STEP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              drv_imm_i,
  input  logic              drv_alu_i,
  input  logic              drv_reg_i,
  input  logic              drv_mem_i,
  input  logic              ld_ir_i,
  input  logic              ld_a_i,
  input  logic              ld_b_i,
  input  logic              ld_ma_i,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_wr_i,
  input  logic [1:0]        ext_sel_i,
  input  logic [2:0]        alu_op_i,
  input  logic              mem_wr_i,
  input  logic [DATA_W-1:0] mem_rdata_i,
  output logic [DATA_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  output logic              mem_we_o,
  output logic [OPC_W-1:0]  opcode_o,
  output logic              a_zero_o,
  output logic [DATA_W-1:0] bus_o
);
  localparam int IDX_W = $clog2(REG_CNT);

  logic [DATA_W-1:0] ir_q, a_q, b_q, ma_q;
  logic [DATA_W-1:0] bus, imm_v, alu_v, reg_v;
  logic [IDX_W-1:0]  rf_idx;

  // shared bus as an AND-OR of gated sources
  always_comb begin
    bus = '0;
    if (drv_imm_i) bus = bus | imm_v;
    if (drv_alu_i) bus = bus | alu_v;
    if (drv_reg_i) bus = bus | reg_v;
    if (drv_mem_i) bus = bus | mem_rdata_i;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ir_q <= '0;
      a_q  <= '0;
      b_q  <= '0;
      ma_q <= '0;
    end else begin
      if (ld_ir_i) ir_q <= bus;
      if (ld_a_i)  a_q  <= bus;
      if (ld_b_i)  b_q  <= bus;
      if (ld_ma_i) ma_q <= bus;
    end
  end

  always_comb begin
    unique case (rsel_e'(reg_sel_i))
      RSEL_SRC: rf_idx = ir_q[SRC_LSB +: IDX_W];
      RSEL_TGT: rf_idx = ir_q[TGT_LSB +: IDX_W];
      RSEL_DST: rf_idx = ir_q[DST_LSB +: IDX_W];
      default:  rf_idx = IDX_W'(REG_CNT - 1);
    endcase
  end

  sbd_regfile #(.DATA_W(DATA_W), .REG_CNT(REG_CNT)) u_rf (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .idx_i     (rf_idx),
    .wr_en_i   (reg_wr_i),
    .wr_data_i (bus),
    .rd_data_o (reg_v)
  );

  sbd_immgen #(.DATA_W(DATA_W)) u_imm (
    .ir_i      (ir_q),
    .ext_sel_i (ext_sel_i),
    .imm_o     (imm_v)
  );

  sbd_alu #(.DATA_W(DATA_W), .INC_STEP(INC_STEP)) u_alu (
    .a_i  (a_q),
    .b_i  (b_q),
    .op_i (alu_op_i),
    .y_o  (alu_v)
  );

  assign mem_addr_o  = ma_q;
  assign mem_wdata_o = bus;
  assign mem_we_o    = mem_wr_i;
  assign opcode_o    = ir_q[DATA_W-1 -: OPC_W];
  assign a_zero_o    = (a_q == '0);
  assign bus_o       = bus;
endmodule

// File: rtl/sbd_checker.sv
module sbd_checker #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        drv,
  input logic              ld_ir,
  input logic              ld_a,
  input logic              ld_ma,
  input logic              drv_reg,
  input logic [IDX_W-1:0]  rf_idx,
  input logic [DATA_W-1:0] bus,
  input logic [DATA_W-1:0] ir_q,
  input logic [DATA_W-1:0] a_q,
  input logic [DATA_W-1:0] mem_addr,
  input logic [5:0]        opcode,
  input logic              a_zero
);
  AST_ONE_DRIVER: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(drv) <= 1); // R1
  AST_IDLE_BUS: assert property (@(posedge clk) disable iff (!rst_n)
    (drv == 4'b0) |-> (bus == '0)); // R1
  AST_IR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_ir |=> $stable(ir_q)); // R2
  AST_A_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    ld_a |=> (a_q == $past(bus))); // R2
  AST_R0_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (drv_reg && rf_idx == '0) |-> (bus == '0)); // R4
  AST_ZERO_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (ld_a && bus == '0) |=> a_zero); // R7
  AST_OPCODE: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ir |=> (opcode == $past(bus[DATA_W-1 -: 6]))); // R7
  AST_MA_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ld_ma |=> (mem_addr == $past(bus))); // R8
endmodule

bind sbus_datapath sbd_checker #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk      (clk_i),
  .rst_n    (rst_ni),
  .drv      ({drv_imm_i, drv_alu_i, drv_reg_i, drv_mem_i}),
  .ld_ir    (ld_ir_i),
  .ld_a     (ld_a_i),
  .ld_ma    (ld_ma_i),
  .drv_reg  (drv_reg_i),
  .rf_idx   (rf_idx),
  .bus      (bus),
  .ir_q     (ir_q),
  .a_q      (a_q),
  .mem_addr (mem_addr_o),
  .opcode   (opcode_o),
  .a_zero   (a_zero_o)
);

// File: tb/sbus_datapath_tb_top.sv
module sbus_datapath_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #4 clk = ~clk;

  logic drv_imm, drv_alu, drv_reg, drv_mem, ld_ir, ld_a, ld_b, ld_ma;
  logic reg_wr, mem_wr;
  logic [1:0] reg_sel, ext_sel;
  logic [2:0] alu_op;
  logic [31:0] mem_rdata, mem_addr, mem_wdata, bus;
  logic mem_we, a_zero;
  logic [5:0] opcode;

  sbus_datapath dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .drv_imm_i(drv_imm), .drv_alu_i(drv_alu), .drv_reg_i(drv_reg), .drv_mem_i(drv_mem),
    .ld_ir_i(ld_ir), .ld_a_i(ld_a), .ld_b_i(ld_b), .ld_ma_i(ld_ma),
    .reg_sel_i(reg_sel), .reg_wr_i(reg_wr), .ext_sel_i(ext_sel), .alu_op_i(alu_op),
    .mem_wr_i(mem_wr), .mem_rdata_i(mem_rdata),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_we_o(mem_we),
    .opcode_o(opcode), .a_zero_o(a_zero), .bus_o(bus)
  );

  typedef enum int {K_BUS, K_OPC, K_ZF, K_ADDR, K_WE, K_WDATA} kind_e;
  typedef struct {
    kind_e kind;
    logic [31:0] val;
    string tag;
  } exp_t;

  exp_t sb_q[$];
  int total = 0;
  int failed = 0;
  bit done = 1'b0;

  task automatic expect_item(input kind_e k, input logic [31:0] v, input string tag);
    exp_t e;
    e.kind = k; e.val = v; e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops expectations a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #2;
      while (sb_q.size() > 0) begin
        exp_t e;
        logic [31:0] act;
        e = sb_q.pop_front();
        case (e.kind)
          K_BUS:   act = bus;
          K_OPC:   act = {26'b0, opcode};
          K_ZF:    act = {31'b0, a_zero};
          K_ADDR:  act = mem_addr;
          K_WE:    act = {31'b0, mem_we};
          default: act = mem_wdata;
        endcase
        total++;
        if (act !== e.val) begin
          failed++;
          $display("FAIL %s kind=%0d actual=%08h expected=%08h", e.tag, e.kind, act, e.val);
        end
      end
    end
  end

  task automatic idle();
    {drv_imm, drv_alu, drv_reg, drv_mem, ld_ir, ld_a, ld_b, ld_ma, reg_wr, mem_wr} = '0;
    reg_sel = 2'd0; ext_sel = 2'd0; alu_op = 3'd0; mem_rdata = 32'h0;
  endtask

  task automatic next();
    @(negedge clk);
    idle();
  endtask

  task automatic from_mem(input logic [31:0] v);
    drv_mem = 1'b1; mem_rdata = v;
  endtask

  task automatic alu_chk(input logic [2:0] op, input logic [31:0] v);
    next(); drv_alu = 1'b1; alu_op = op; expect_item(K_BUS, v, "R6 alu");
  endtask

  task automatic imm_chk(input logic [1:0] sel, input logic [31:0] v);
    next(); drv_imm = 1'b1; ext_sel = sel; expect_item(K_BUS, v, "R5 imm");
  endtask

  task automatic reg_chk(input logic [1:0] sel, input logic [31:0] v, input string tag);
    next(); drv_reg = 1'b1; reg_sel = sel; expect_item(K_BUS, v, tag);
  endtask

  localparam logic [31:0] IR1 = 32'h8CA7_4804; // op 23, src 5, tgt 7, dst 9
  localparam logic [31:0] IR2 = 32'h1000_8000; // op 04, src 0, tgt 0

  initial begin
    idle();
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    // reset state
    next();
    expect_item(K_BUS, 32'h0, "R1 idle bus");
    expect_item(K_OPC, 32'h0, "R9 reset opcode");
    expect_item(K_ZF, 32'h1, "R9 reset a_zero");
    expect_item(K_ADDR, 32'h0, "R9 reset addr");
    reg_chk(2'd3, 32'h0, "R9 reset link");
    // fetch IR1
    next(); from_mem(IR1); ld_ir = 1'b1; expect_item(K_BUS, IR1, "R8 mem onto bus");
    next(); expect_item(K_OPC, 32'h23, "R7 opcode");
    from_mem(32'h10); reg_wr = 1'b1; reg_sel = 2'd0;
    next(); from_mem(32'h3); reg_wr = 1'b1; reg_sel = 2'd1;
    next(); from_mem(32'h0040_0000); reg_wr = 1'b1; reg_sel = 2'd3;
    next(); from_mem(32'h55); reg_wr = 1'b1; reg_sel = 2'd2;
    reg_chk(2'd0, 32'h10, "R3 src read"); ld_a = 1'b1;
    reg_chk(2'd1, 32'h3, "R3 tgt read"); ld_b = 1'b1;
    expect_item(K_ZF, 32'h0, "R7 a nonzero");
    reg_chk(2'd3, 32'h0040_0000, "R3 link read");
    reg_chk(2'd2, 32'h55, "R3 dst read");
    alu_chk(3'd0, 32'h13);
    alu_chk(3'd1, 32'hD);
    alu_chk(3'd2, 32'h0);
    alu_chk(3'd3, 32'h13);
    alu_chk(3'd4, 32'h13);
    alu_chk(3'd5, 32'h0);
    alu_chk(3'd6, 32'h14);
    alu_chk(3'd7, 32'hC);
    imm_chk(2'd0, 32'h0000_4804);
    imm_chk(2'd1, 32'h0001_2010);
    imm_chk(2'd2, 32'h00A7_4804);
    imm_chk(2'd3, 32'h0000_4804);
    // R2 hold: bus busy, no load
    next(); from_mem(32'hDEAD_BEEF); expect_item(K_BUS, 32'hDEAD_BEEF, "R2 bus busy");
    next(); drv_alu = 1'b1; alu_op = 3'd0; expect_item(K_BUS, 32'h13, "R2 A/B held");
    expect_item(K_OPC, 32'h23, "R2 IR held");
    // R8 memory address and write strobe
    reg_chk(2'd0, 32'h10, "R8 addr source"); ld_ma = 1'b1; mem_wr = 1'b1;
    expect_item(K_WE, 32'h1, "R8 we high");
    expect_item(K_WDATA, 32'h10, "R8 wdata");
    next(); expect_item(K_ADDR, 32'h10, "R8 addr"); expect_item(K_WE, 32'h0, "R8 we low");
    // IR2: zero fields, negative immediate
    next(); from_mem(IR2); ld_ir = 1'b1;
    next(); expect_item(K_OPC, 32'h04, "R7 opcode 2");
    from_mem(32'hFFFF_FFFF); reg_wr = 1'b1; reg_sel = 2'd0;
    reg_chk(2'd0, 32'h0, "R4 r0 read"); ld_a = 1'b1;
    reg_chk(2'd1, 32'h0, "R4 r0 via tgt");
    expect_item(K_ZF, 32'h1, "R7 a zero");
    reg_chk(2'd3, 32'h0040_0000, "R4 link untouched");
    imm_chk(2'd0, 32'hFFFF_8000);
    imm_chk(2'd1, 32'hFFFE_0000);
    imm_chk(2'd3, 32'h0000_8000);
    imm_chk(2'd2, 32'h0000_8000); ld_b = 1'b1;
    next(); from_mem(32'hA000_0000); ld_a = 1'b1;
    alu_chk(3'd7, 32'hA002_0000);
    alu_chk(3'd5, 32'h1);
    alu_chk(3'd1, 32'h9FFF_8000);
    next();
    next();
    done = 1'b1;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++;
      failed++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("%0d/%0d checks passed", total - failed, total);
      $finish;
    end
  end
endmodule